// File: doc/BRIEF.md
# Predicated Bundle Issue Stage

This block sits between an instruction fetch queue and the execution lanes of an in-order, statically scheduled core. It takes fixed 128-bit instruction packets, each holding a 5-bit template and three 41-bit instruction slots. It holds them in a small buffer. It sends out up to two packets, which is six slots, per clock. Each slot leaves with a valid flag and a predicate-enable flag.

Bit 0 of the template marks the end of an issue group. When that bit is clear in the oldest buffered packet, the next packet joins the same group and leaves in the same cycle. When it is set, the next packet waits one cycle. Each slot names one of 64 one-bit predicate registers in its low six bits. That register's current value becomes the slot's enable, so a false predicate squashes the instruction without a branch.

The predicate registers live in the block. Compare units update them through two write ports. Register 0 always reads as true. A stall input freezes issue and holds all buffered packets in place.

Top module: `bundle_dispatch`

## Requirements
- R1: After synchronous active-low reset, no slot is valid, `in_ready` is high, the buffer is empty, and predicate registers 1 to 63 read false.
- R2: Bit layout of a packet: template in bits [4:0], slot 0 in [45:5], slot 1 in [86:46], slot 2 in [127:87]. Lane L = 3*b + s (packet position b, slot s) appears on `iss_slot[41*L +: 41]`. Template bits [4:1] of packet b appear on `iss_hint[4*b +: 4]`, and template bit 0 appears on `iss_stop[b]`.
- R3: With one packet buffered and no stall, exactly `iss_valid[2:0]` are high, and that packet leaves the buffer at the next edge.
- R4: The second packet issues in the same cycle as the first only when the first packet's template bit 0 is 0. Otherwise it waits and issues in the next cycle as packet position 0.
- R5: While `stall` is high, all of `iss_valid` is low and buffered packets are neither dropped nor reordered.
- R6: The buffer holds 4 packets by default. When it is full, `in_ready` is low and a packet offered on `in_valid` is not taken.
- R7: `iss_pen` of a valid slot equals the predicate register selected by slot bits [5:0]. It is 0 on invalid lanes.
- R8: Packets leave in exactly the order they were accepted.
- R9: A predicate write lands at the clock edge. A slot issuing in the same cycle sees the old value. If both ports write the same register, port 1 wins.
- R10: Predicate register 0 always reads true and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| stall | input | 1 | Freeze issue and hold buffered packets |
| in_valid | input | 1 | Packet offered by the fetch queue |
| in_bundle | input | 128 | Offered packet |
| in_ready | output | 1 | Buffer can take a packet this cycle |
| pw_en | input | 2 | Predicate write enable, one per port |
| pw_idx | input | 12 | Predicate index, 6 bits per port (port p at [6p+:6]) |
| pw_val | input | 2 | Predicate write value, one per port |
| iss_valid | output | 6 | Slot valid per lane |
| iss_pen | output | 6 | Predicate enable per lane |
| iss_slot | output | 246 | Slot contents, 41 bits per lane |
| iss_hint | output | 8 | Template bits [4:1] per packet position |
| iss_stop | output | 2 | End-of-group bit per issued packet position |

## Verification
The hardest state to reach from the ports is a buffer holding two or more packets, because with no stall each packet leaves the cycle after it arrives. The bench raises `stall` while it pushes packets. This builds a known queue, from a chained pair up to a full buffer, and then releases the stall. The same-cycle predicate race needs a write that lines up with the cycle a particular packet issues. The bench parks the packet at the head of the buffer before it drives the write ports in that exact cycle.

// File: rtl/bdisp_pkg.sv
`timescale 1ns/1ps
// Shared sizes and types for the bundle issue stage.
// Assumes the packet is exactly NSLOT*SLOT_W + TMPL_W bits wide.
package bdisp_pkg;
    localparam int SLOT_W   = 41;
    localparam int TMPL_W   = 5;
    localparam int NSLOT    = 3;
    localparam int SEL_W    = 6;
    localparam int NPRED    = 1 << SEL_W;
    localparam int BUNDLE_W = NSLOT * SLOT_W + TMPL_W;
    localparam int HINT_W   = TMPL_W - 1;

    typedef logic [SLOT_W-1:0] slot_t;

    // Packed so that the template is bits [4:0] and slot 0 sits just above it.
    typedef struct packed {
        slot_t [NSLOT-1:0]  slot;
        logic [TMPL_W-1:0]  tmpl;
    } bundle_t;
endpackage

// File: rtl/bdisp_fifo.sv
`timescale 1ns/1ps
// Circular packet buffer. It accepts one packet per cycle and retires
// 0..WIN packets per cycle from the head.
// Exposes the oldest WIN entries as a window.
// Assumes pop_n never exceeds the current count and WIN <= DEPTH.
module bdisp_fifo
    import bdisp_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int WIN   = 2,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int NW   = $clog2(WIN + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                push_valid,
    input  bundle_t             push_data,
    output logic                push_ready,
    input  logic [NW-1:0]       pop_n,
    output bundle_t [WIN-1:0]   win_o,
    output logic [CW-1:0]       count_o
);
    bundle_t        mem [DEPTH];
    logic [PW-1:0]  head;
    logic [CW-1:0]  count;
    logic           push;

    // Wrap-around addition of an offset to a buffer index.
    function automatic logic [PW-1:0] wrap(input logic [PW-1:0] a, input int unsigned off);
        int unsigned s;
        s = int'(a) + off;
        if (s >= DEPTH) s = s - DEPTH;
        return PW'(s);
    endfunction

    assign push_ready = (count < CW'(DEPTH));
    assign push       = push_valid && push_ready;
    assign count_o    = count;

    // Present the oldest WIN entries to the issue logic.
    for (genvar w = 0; w < WIN; w++) begin : g_win
        assign win_o[w] = mem[wrap(head, w)];
    end

    // Store a packet at the tail when one is accepted.
    always_ff @(posedge clk) begin
        if (push) mem[wrap(head, int'(count))] <= push_data;
    end

    // Advance the head and track occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head  <= '0;
            count <= '0;
        end else begin
            head  <= wrap(head, int'(pop_n));
            count <= count + CW'(push) - CW'(pop_n);
        end
    end

    // R6: a full buffer never signals room.
    a_r6_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (count == CW'(DEPTH)) |-> !push_ready);

    // R6: occupancy stays within capacity.
    a_r6_within_depth: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
endmodule

// File: rtl/bdisp_predfile.sv
`timescale 1ns/1ps
// One-bit predicate register file with NPW write ports and a full parallel
// read vector. Entry 0 is fixed true. A higher-numbered port wins a collision.
// Assumes writes land at the clock edge and readers see the pre-edge value.
module bdisp_predfile
    import bdisp_pkg::*;
#(
    parameter int NPW = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NPW-1:0]        pw_en,
    input  logic [NPW*SEL_W-1:0]  pw_idx,
    input  logic [NPW-1:0]        pw_val,
    output logic [NPRED-1:0]      pred_o
);
    logic [NPRED-1:1] regs;
    logic [SEL_W-1:0] last_idx;

    assign pred_o   = {regs, 1'b1};
    assign last_idx = pw_idx[(NPW-1)*SEL_W +: SEL_W];

    // Apply the write ports in order so the last port takes priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs <= '0;
        end else begin
            for (int p = 0; p < NPW; p++) begin
                if (pw_en[p] && (pw_idx[p*SEL_W +: SEL_W] != '0))
                    regs[pw_idx[p*SEL_W +: SEL_W]] <= pw_val[p];
            end
        end
    end

    // R9: the highest port's write is visible after the edge.
    a_r9_last_port_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (pw_en[NPW-1] && last_idx != '0) |=> pred_o[$past(last_idx)] == $past(pw_val[NPW-1]));
endmodule

// File: rtl/bdisp_slot_gate.sv
`timescale 1ns/1ps
// Splits one packet position into slot valid and predicate-enable flags.
// Each slot looks up the predicate named by its low SEL_W bits.
// Assumes pred_i carries the register values from before this edge.
module bdisp_slot_gate
    import bdisp_pkg::*;
(
    input  bundle_t             bnd_i,
    input  logic                bv_i,
    input  logic [NPRED-1:0]    pred_i,
    output logic [NSLOT-1:0]    sv_o,
    output logic [NSLOT-1:0]    pen_o
);
    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        logic [SEL_W-1:0] sel;
        assign sel      = bnd_i.slot[s][SEL_W-1:0];
        assign sv_o[s]  = bv_i;
        assign pen_o[s] = bv_i && pred_i[sel];
    end
endmodule

// File: rtl/bundle_dispatch.sv
`timescale 1ns/1ps
// In-order, predicated issue stage. Buffers fetched packets and issues up to
// ISSUE_B of them per clock. A later packet joins only while every earlier
// packet in the window has a clear end-of-group bit.
// Assumes ISSUE_B <= DEPTH and that downstream takes every issued lane.
module bundle_dispatch
    import bdisp_pkg::*;
#(
    parameter int DEPTH   = 4,
    parameter int ISSUE_B = 2,
    parameter int NPW     = 2,
    localparam int NLANE  = ISSUE_B * NSLOT,
    localparam int CW     = $clog2(DEPTH + 1),
    localparam int NW     = $clog2(ISSUE_B + 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        stall,
    input  logic                        in_valid,
    input  logic [BUNDLE_W-1:0]         in_bundle,
    output logic                        in_ready,
    input  logic [NPW-1:0]              pw_en,
    input  logic [NPW*SEL_W-1:0]        pw_idx,
    input  logic [NPW-1:0]              pw_val,
    output logic [NLANE-1:0]            iss_valid,
    output logic [NLANE-1:0]            iss_pen,
    output logic [NLANE*SLOT_W-1:0]     iss_slot,
    output logic [ISSUE_B*HINT_W-1:0]   iss_hint,
    output logic [ISSUE_B-1:0]          iss_stop
);
    bundle_t [ISSUE_B-1:0]  win;
    logic [CW-1:0]          count;
    logic [ISSUE_B:0]       chain;
    logic [ISSUE_B-1:0]     bv;
    logic [NW-1:0]          pop_n;
    logic [NPRED-1:0]       pred;

    bdisp_fifo #(.DEPTH(DEPTH), .WIN(ISSUE_B)) u_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_valid (in_valid),
        .push_data  (bundle_t'(in_bundle)),
        .push_ready (in_ready),
        .pop_n      (pop_n),
        .win_o      (win),
        .count_o    (count)
    );

    bdisp_predfile #(.NPW(NPW)) u_pred (
        .clk    (clk),
        .rst_n  (rst_n),
        .pw_en  (pw_en),
        .pw_idx (pw_idx),
        .pw_val (pw_val),
        .pred_o (pred)
    );

    assign chain[0] = 1'b1;

    for (genvar b = 0; b < ISSUE_B; b++) begin : g_pos
        // A position issues if it is occupied and all earlier positions chain on.
        assign chain[b+1] = chain[b] && !win[b].tmpl[0];
        assign bv[b]      = !stall && (count > CW'(b)) && chain[b];

        bdisp_slot_gate u_gate (
            .bnd_i  (win[b]),
            .bv_i   (bv[b]),
            .pred_i (pred),
            .sv_o   (iss_valid[b*NSLOT +: NSLOT]),
            .pen_o  (iss_pen[b*NSLOT +: NSLOT])
        );

        for (genvar s = 0; s < NSLOT; s++) begin : g_lane
            assign iss_slot[(b*NSLOT + s)*SLOT_W +: SLOT_W] = win[b].slot[s];
        end

        assign iss_hint[b*HINT_W +: HINT_W] = win[b].tmpl[TMPL_W-1:1];
        assign iss_stop[b] = bv[b] && win[b].tmpl[0];
    end

    assign pop_n = NW'($countones(bv));

    // R5: nothing issues while stalled.
    a_r5_stall_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (iss_valid == '0));

    // R5: the head packet is held across a stalled cycle.
    a_r5_head_held: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && count != '0) |=> (win[0] == $past(win[0])));

    // R4: a second packet only rides along behind an open group.
    a_r4_second_chains: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid[NSLOT] |-> (iss_valid[0] && !iss_stop[0]));

    // R7: a squashed lane is never enabled.
    a_r7_pen_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_pen & ~iss_valid) == '0);
endmodule

// File: tb/tb_bundle_dispatch.sv
`timescale 1ns/1ps
// Directed bench for bundle_dispatch, with one task per scenario.
module tb_bundle_dispatch;
    logic         clk = 0;
    logic         rst_n = 0;
    logic         stall = 0;
    logic         in_valid = 0;
    logic [127:0] in_bundle = '0;
    logic         in_ready;
    logic [1:0]   pw_en = '0;
    logic [11:0]  pw_idx = '0;
    logic [1:0]   pw_val = '0;
    logic [5:0]   iss_valid, iss_pen;
    logic [245:0] iss_slot;
    logic [7:0]   iss_hint;
    logic [1:0]   iss_stop;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    bundle_dispatch dut (
        .clk(clk), .rst_n(rst_n), .stall(stall), .in_valid(in_valid),
        .in_bundle(in_bundle), .in_ready(in_ready), .pw_en(pw_en),
        .pw_idx(pw_idx), .pw_val(pw_val), .iss_valid(iss_valid),
        .iss_pen(iss_pen), .iss_slot(iss_slot), .iss_hint(iss_hint),
        .iss_stop(iss_stop)
    );

    function automatic logic [40:0] mkslot(input logic [7:0] tag, input int k, input logic [5:0] sel);
        return {19'h0, tag, 8'(k), sel};
    endfunction

    function automatic logic [127:0] mk(input logic [7:0] tag, input logic stop, input logic [3:0] hint,
                                        input logic [5:0] s0, input logic [5:0] s1, input logic [5:0] s2);
        return {mkslot(tag, 2, s2), mkslot(tag, 1, s1), mkslot(tag, 0, s0), hint, stop};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [40:0] lane(input int l);
        return iss_slot[41*l +: 41];
    endfunction

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        chk("R1 valid", 64'(iss_valid), 64'h0);
        chk("R1 ready", 64'(in_ready), 64'h1);
        chk("R1 stop", 64'(iss_stop), 64'h0);
    endtask

    task automatic t_single();
        @(negedge clk); in_valid = 1; in_bundle = mk(8'd1, 1'b1, 4'hA, 6'd0, 6'd0, 6'd0);
        @(negedge clk); in_valid = 0; #1;
        chk("R3 valid", 64'(iss_valid), 64'h07);
        chk("R2 slot0", 64'(lane(0)), 64'(mkslot(8'd1, 0, 6'd0)));
        chk("R2 slot2", 64'(lane(2)), 64'(mkslot(8'd1, 2, 6'd0)));
        chk("R2 hint", 64'(iss_hint[3:0]), 64'hA);
        chk("R2 stop", 64'(iss_stop), 64'h1);
        @(negedge clk); #1;
        chk("R3 retired", 64'(iss_valid), 64'h0);
    endtask

    task automatic t_pred_reset();
        @(negedge clk); in_valid = 1; in_bundle = mk(8'd2, 1'b1, 4'h0, 6'd0, 6'd1, 6'd63);
        @(negedge clk); in_valid = 0; #1;
        chk("R7 R1 pen after reset", 64'(iss_pen), 64'h01);
    endtask

    task automatic t_chain();
        @(negedge clk); stall = 1; in_valid = 1; in_bundle = mk(8'd3, 1'b0, 4'h5, 6'd0, 6'd0, 6'd0);
        @(negedge clk); in_bundle = mk(8'd4, 1'b1, 4'h6, 6'd0, 6'd0, 6'd0);
        @(negedge clk); in_valid = 0; #1;
        chk("R5 stalled", 64'(iss_valid), 64'h0);
        stall = 0; #1;
        chk("R4 pair", 64'(iss_valid), 64'h3F);
        chk("R8 first", 64'(lane(0)), 64'(mkslot(8'd3, 0, 6'd0)));
        chk("R8 second", 64'(lane(3)), 64'(mkslot(8'd4, 0, 6'd0)));
        chk("R2 hints", 64'(iss_hint), 64'h65);
        chk("R2 stops", 64'(iss_stop), 64'h2);
        @(negedge clk); #1;
        chk("R4 pair retired", 64'(iss_valid), 64'h0);
    endtask

    task automatic t_split();
        @(negedge clk); stall = 1; in_valid = 1; in_bundle = mk(8'd5, 1'b1, 4'h0, 6'd0, 6'd0, 6'd0);
        @(negedge clk); in_bundle = mk(8'd6, 1'b0, 4'h0, 6'd0, 6'd0, 6'd0);
        @(negedge clk); in_valid = 0; stall = 0; #1;
        chk("R4 split first", 64'(iss_valid), 64'h07);
        chk("R4 split tag", 64'(lane(0)), 64'(mkslot(8'd5, 0, 6'd0)));
        @(negedge clk); #1;
        chk("R4 split next", 64'(iss_valid), 64'h07);
        chk("R8 split tag", 64'(lane(0)), 64'(mkslot(8'd6, 0, 6'd0)));
        @(negedge clk); #1;
        chk("R4 split empty", 64'(iss_valid), 64'h0);
    endtask

    task automatic t_full();
        stall = 1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); in_valid = 1; in_bundle = mk(8'(7 + i), 1'b1, 4'h0, 6'd0, 6'd0, 6'd0);
        end
        @(negedge clk); in_bundle = mk(8'd11, 1'b1, 4'h0, 6'd0, 6'd0, 6'd0); #1;
        chk("R6 ready low when full", 64'(in_ready), 64'h0);
        @(negedge clk); in_valid = 0; stall = 0;
        for (int i = 0; i < 4; i++) begin
            #1;
            chk("R6 R8 drain order", 64'(lane(0)), 64'(mkslot(8'(7 + i), 0, 6'd0)));
            @(negedge clk);
        end
        #1;
        chk("R6 extra not taken", 64'(iss_valid), 64'h0);
    endtask

    task automatic t_pred_write();
        @(negedge clk); in_valid = 1; in_bundle = mk(8'd12, 1'b1, 4'h0, 6'd5, 6'd0, 6'd7);
        @(negedge clk); in_valid = 0;
        pw_en = 2'b11; pw_idx = {6'd0, 6'd5}; pw_val = 2'b01; #1;
        chk("R9 old value same cycle", 64'(iss_pen), 64'h02);
        @(negedge clk); pw_en = 2'b00; in_valid = 1; in_bundle = mk(8'd13, 1'b1, 4'h0, 6'd5, 6'd0, 6'd7);
        @(negedge clk); in_valid = 0; #1;
        chk("R9 R10 new value", 64'(iss_pen), 64'h03);
        pw_en = 2'b11; pw_idx = {6'd7, 6'd7}; pw_val = 2'b10;
        @(negedge clk); pw_en = 2'b00; in_valid = 1; in_bundle = mk(8'd14, 1'b1, 4'h0, 6'd7, 6'd7, 6'd0);
        @(negedge clk); in_valid = 0; #1;
        chk("R9 port1 wins", 64'(iss_pen), 64'h07);
        @(negedge clk);
    endtask

    initial begin
        t_reset();
        t_single();
        t_pred_reset();
        t_chain();
        t_split();
        t_full();
        t_pred_write();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule